// File: doc/BRIEF.md
# Context Capture Frame Packer

This block saves the flip-flop state of one reconfigurable region of logic. It talks to the device's configuration port through a command channel and a 32-bit read-data channel. When it gets a start pulse with a list of frame addresses, it first holds the region's clock enable low. It then issues an option write and a single-edge global capture command. After that it reads back each listed frame in turn. Once every frame has been read, it sends a capture-reset command so that later saves can capture again, and then releases the clock.

While this runs, the block produces a self-describing context record on a word-wide output stream. The record starts with the frame count. The addresses follow, and then the contents of every frame in list order. A scheduler that preempts a task uses this record to resume the task later, in the same region or in another one. The count and the address list are latched at start, so the caller may change them while a save is running. Frame data passes straight from the read channel to the output, so no frame buffer is needed.

Top module: `ctx_snap_packer`

## Requirements
- R1: After reset, `busy` is 0, `region_clk_en` is 1, and both `cmd_valid` and `rec_valid` are 0.
- R2: A `start` pulse in idle with `frame_cnt` from 1 to MAX_FRAMES begins a save and latches the count and address list. Address slot i is taken from `frame_addrs[32*i +: 32]`. A `start` with `frame_cnt` of 0 or above MAX_FRAMES is ignored: no command and no record word appear.
- R3: `region_clk_en` falls in the cycle after an accepted start. It stays low through every command and every readback word, and no read-data word is accepted while it is high.
- R4: Commands are accepted in this order: the option word, the capture word, then for each frame the read word followed by that frame's address, and finally the capture-reset word.
- R5: Exactly 41 read-data words are accepted for each listed frame.
- R6: The record holds 1 + N + 41·N words. Word 0 is N, zero-extended. Words 1..N are the addresses in slot order. These are followed by the frames' data in the same order, each word as read. A header word stays stable while it is not accepted.
- R7: `rec_last` is 1 on the final record word only.
- R8: `region_clk_en` returns to 1 in the cycle after the capture-reset word is accepted, and `busy` falls at the same edge. `busy` is still 1 when the last record word is accepted.
- R9: A `start` while `busy` is 1 is ignored: the running save and its record are unchanged, and no second save follows.
- R10: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid` and `cmd_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to save the region's context |
| frame_cnt | input | CNT_W | Number of frames to read (N) |
| frame_addrs | input | 32·MAX_FRAMES | Frame address list, slot i at bits 32·i upward |
| busy | output | 1 | Save in progress |
| region_clk_en | output | 1 | Clock enable for the reconfigurable region |
| cmd_valid | output | 1 | Command word valid |
| cmd_ready | input | 1 | Configuration port accepts command word |
| cmd_data | output | 32 | Command or frame address word |
| rd_valid | input | 1 | Read-data word valid |
| rd_ready | output | 1 | Block accepts read-data word |
| rd_data | input | 32 | Read-data word from the configuration port |
| rec_valid | output | 1 | Record word valid |
| rec_ready | input | 1 | Sink accepts record word |
| rec_data | output | 32 | Record word |
| rec_last | output | 1 | Final word of the record |

## Verification
The assertions check the following on every cycle:
- No read-data word is taken while the region clock runs.
- Commands and header words hold while they are stalled.
- The clock comes back only right after a capture-reset handshake.
- The word counter never passes the frame length.
- A start cannot end a save early.

Only the bench scenarios can show the rest:
- the full order of commands;
- the record's content and length for different counts and address lists;
- the position of the last flag;
- the rejection of out-of-range counts;
- that a start pulse during a save leaves the latched list and the record untouched.

// File: rtl/ctx_snap_pkg.sv
package ctx_snap_pkg;
    localparam int WORD_W      = 32;
    localparam int FRAME_WORDS = 41;
    localparam int WIDX_W      = $clog2(FRAME_WORDS);

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_HDR_CNT,
        PH_HDR_ADDR,
        PH_OPT,
        PH_CAP,
        PH_RD_CMD,
        PH_RD_ADDR,
        PH_DATA,
        PH_RCAP
    } phase_t;

    typedef struct packed {
        logic  valid;
        word_t data;
    } beat_t;

    function automatic int record_words(input int n);
        return 1 + n + FRAME_WORDS * n;
    endfunction
endpackage

// File: rtl/ctx_step_ctr.sv
module ctx_step_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (inc) begin
            q <= q + 1'b1;
        end
    end
endmodule

// File: rtl/ctx_addr_bank.sv
module ctx_addr_bank
    import ctx_snap_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int IDX_W = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [SLOTS*WORD_W-1:0] list,
    input  logic [IDX_W-1:0]        idx,
    output word_t                   addr
);
    word_t slot [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[i] <= '0;
            end else if (load) begin
                slot[i] <= list[i*WORD_W +: WORD_W];
            end
        end
    end

    always_comb begin
        addr = '0;
        if (int'(idx) < SLOTS) begin
            addr = slot[idx];
        end
    end
endmodule

// File: rtl/ctx_snap_fsm.sv
module ctx_snap_fsm
    import ctx_snap_pkg::*;
#(
    parameter int MAX_FRAMES = 4,
    parameter int CNT_W      = 3,
    parameter int IDX_W      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              cmd_ready,
    input  logic              rd_valid,
    input  logic              rec_ready,
    input  logic [IDX_W-1:0]  fidx,
    input  logic [WIDX_W-1:0] widx,
    output phase_t            phase,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              on_last_frame,
    output logic              load,
    output logic              fidx_clr,
    output logic              fidx_inc,
    output logic              widx_clr,
    output logic              widx_inc,
    output logic              clk_en
);
    localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(FRAME_WORDS - 1);

    phase_t nxt;
    logic   cnt_ok;

    assign cnt_ok        = (cnt_in != '0) && (int'(cnt_in) <= MAX_FRAMES);
    assign on_last_frame = ((CNT_W'(fidx) + 1'b1) == cnt_q);

    always_comb begin
        nxt      = phase;
        load     = 1'b0;
        fidx_clr = 1'b0;
        fidx_inc = 1'b0;
        widx_clr = 1'b0;
        widx_inc = 1'b0;
        unique case (phase)
            PH_IDLE: if (start && cnt_ok) begin
                nxt      = PH_HDR_CNT;
                load     = 1'b1;
                fidx_clr = 1'b1;
                widx_clr = 1'b1;
            end
            PH_HDR_CNT: if (rec_ready) nxt = PH_HDR_ADDR;
            PH_HDR_ADDR: if (rec_ready) begin
                if (on_last_frame) begin
                    nxt      = PH_OPT;
                    fidx_clr = 1'b1;
                end else begin
                    fidx_inc = 1'b1;
                end
            end
            PH_OPT:    if (cmd_ready) nxt = PH_CAP;
            PH_CAP:    if (cmd_ready) nxt = PH_RD_CMD;
            PH_RD_CMD: if (cmd_ready) nxt = PH_RD_ADDR;
            PH_RD_ADDR: if (cmd_ready) begin
                nxt      = PH_DATA;
                widx_clr = 1'b1;
            end
            PH_DATA: if (rd_valid && rec_ready) begin
                if (widx == LAST_W) begin
                    widx_clr = 1'b1;
                    if (on_last_frame) begin
                        nxt = PH_RCAP;
                    end else begin
                        fidx_inc = 1'b1;
                        nxt      = PH_RD_CMD;
                    end
                end else begin
                    widx_inc = 1'b1;
                end
            end
            PH_RCAP: if (cmd_ready) nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt_q  <= '0;
            clk_en <= 1'b1;
        end else begin
            phase <= nxt;
            if (load) begin
                cnt_q  <= cnt_in;
                clk_en <= 1'b0;
            end else if (phase == PH_RCAP && cmd_ready) begin
                clk_en <= 1'b1;
            end
        end
    end

    // R5
    frame_len_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA) |-> (widx <= LAST_W));
endmodule

// File: rtl/ctx_snap_packer.sv
module ctx_snap_packer
    import ctx_snap_pkg::*;
#(
    parameter int          MAX_FRAMES = 4,
    parameter logic [31:0] OPT_WORD   = 32'h3001_2001,
    parameter logic [31:0] CAP_WORD   = 32'h0000_000C,
    parameter logic [31:0] RDCMD_WORD = 32'h2800_6000,
    parameter logic [31:0] RCAP_WORD  = 32'h0000_0006,
    localparam int CNT_W = $clog2(MAX_FRAMES + 1),
    localparam int IDX_W = (MAX_FRAMES > 1) ? $clog2(MAX_FRAMES) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [CNT_W-1:0]           frame_cnt,
    input  logic [MAX_FRAMES*32-1:0]   frame_addrs,
    output logic                       busy,
    output logic                       region_clk_en,
    output logic                       cmd_valid,
    input  logic                       cmd_ready,
    output logic [31:0]                cmd_data,
    input  logic                       rd_valid,
    output logic                       rd_ready,
    input  logic [31:0]                rd_data,
    output logic                       rec_valid,
    input  logic                       rec_ready,
    output logic [31:0]                rec_data,
    output logic                       rec_last
);
    localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(FRAME_WORDS - 1);

    phase_t            phase;
    logic [CNT_W-1:0]  cnt_q;
    logic              on_last_frame, load;
    logic              fidx_clr, fidx_inc, widx_clr, widx_inc;
    logic [IDX_W-1:0]  fidx;
    logic [WIDX_W-1:0] widx;
    word_t             cur_addr;
    beat_t             cmd_b, rec_b;

    ctx_snap_fsm #(.MAX_FRAMES(MAX_FRAMES), .CNT_W(CNT_W), .IDX_W(IDX_W)) fsm_i (
        .clk(clk), .rst(rst), .start(start), .cnt_in(frame_cnt),
        .cmd_ready(cmd_ready), .rd_valid(rd_valid), .rec_ready(rec_ready),
        .fidx(fidx), .widx(widx), .phase(phase), .cnt_q(cnt_q),
        .on_last_frame(on_last_frame), .load(load),
        .fidx_clr(fidx_clr), .fidx_inc(fidx_inc),
        .widx_clr(widx_clr), .widx_inc(widx_inc), .clk_en(region_clk_en)
    );

    ctx_step_ctr #(.W(IDX_W)) frame_ctr_i (
        .clk(clk), .rst(rst), .clr(fidx_clr), .inc(fidx_inc), .q(fidx)
    );

    ctx_step_ctr #(.W(WIDX_W)) word_ctr_i (
        .clk(clk), .rst(rst), .clr(widx_clr), .inc(widx_inc), .q(widx)
    );

    ctx_addr_bank #(.SLOTS(MAX_FRAMES), .IDX_W(IDX_W)) bank_i (
        .clk(clk), .rst(rst), .load(load), .list(frame_addrs),
        .idx(fidx), .addr(cur_addr)
    );

    always_comb begin
        cmd_b = '0;
        unique case (phase)
            PH_OPT:     cmd_b = '{valid: 1'b1, data: OPT_WORD};
            PH_CAP:     cmd_b = '{valid: 1'b1, data: CAP_WORD};
            PH_RD_CMD:  cmd_b = '{valid: 1'b1, data: RDCMD_WORD};
            PH_RD_ADDR: cmd_b = '{valid: 1'b1, data: cur_addr};
            PH_RCAP:    cmd_b = '{valid: 1'b1, data: RCAP_WORD};
            default:    cmd_b = '0;
        endcase
    end

    always_comb begin
        rec_b = '0;
        unique case (phase)
            PH_HDR_CNT:  rec_b = '{valid: 1'b1, data: WORD_W'(cnt_q)};
            PH_HDR_ADDR: rec_b = '{valid: 1'b1, data: cur_addr};
            PH_DATA:     rec_b = '{valid: rd_valid, data: rd_data};
            default:     rec_b = '0;
        endcase
    end

    assign cmd_valid = cmd_b.valid;
    assign cmd_data  = cmd_b.data;
    assign rec_valid = rec_b.valid;
    assign rec_data  = rec_b.data;
    assign rd_ready  = (phase == PH_DATA) && rec_ready;
    assign rec_last  = (phase == PH_DATA) && rd_valid && (widx == LAST_W) && on_last_frame;
    assign busy      = (phase != PH_IDLE);

    // R3
    readback_clk_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        rd_ready |-> !region_clk_en);

    // R10
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

    // R6
    hdr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_ready && phase != PH_DATA) |=> (rec_valid && $stable(rec_data)));

    // R8
    clk_restore_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(region_clk_en) |-> $past(cmd_valid && cmd_ready && phase == PH_RCAP));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && phase != PH_RCAP) |=> busy);

    // R7
    last_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rec_last |-> (rec_valid && !cmd_valid));
endmodule

// File: tb/ctx_snap_packer_tb.sv
module ctx_snap_packer_tb_top;
    localparam int          MAXF   = 4;
    localparam int          CNT_W  = 3;
    localparam logic [31:0] W_OPT  = 32'h3001_2001;
    localparam logic [31:0] W_CAP  = 32'h0000_000C;
    localparam logic [31:0] W_RD   = 32'h2800_6000;
    localparam logic [31:0] W_RCAP = 32'h0000_0006;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic               start = 1'b0;
    logic [CNT_W-1:0]   frame_cnt = '0;
    logic [MAXF*32-1:0] frame_addrs = '0;
    logic busy, region_clk_en, cmd_valid, cmd_ready, rd_valid, rd_ready;
    logic rec_valid, rec_ready, rec_last;
    logic [31:0] cmd_data, rd_data, rec_data;

    ctx_snap_packer #(
        .MAX_FRAMES(MAXF), .OPT_WORD(W_OPT), .CAP_WORD(W_CAP),
        .RDCMD_WORD(W_RD), .RCAP_WORD(W_RCAP)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start), .frame_cnt(frame_cnt),
        .frame_addrs(frame_addrs), .busy(busy), .region_clk_en(region_clk_en),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data),
        .rec_last(rec_last)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] cmd_log [256];
    logic [31:0] rec_log [256];
    logic        last_log [256];
    int          ncmd, nrec, bad_en_hs;
    logic        busy_at_last;
    logic        want_addr;
    logic [31:0] cur_addr;
    int          rd_left, rd_k;

    function automatic logic [31:0] pat(input logic [31:0] a, input int k);
        return a ^ (32'(k) * 32'h9E37_79B9) ^ 32'h5A5A_0000;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        ncmd = 0; nrec = 0; bad_en_hs = 0; busy_at_last = 1'b0;
        want_addr = 1'b0; rd_left = 0; rd_k = 0;
    endtask

    // configuration port model, record sink and handshake monitor
    initial begin
        cmd_ready = 1'b0; rec_ready = 1'b0; rd_valid = 1'b0; rd_data = '0;
        clear_logs();
        forever begin
            @(negedge clk);
            cmd_ready = ($urandom % 4) != 0;
            rec_ready = ($urandom % 3) != 0;
            if (rd_left > 0) begin
                rd_valid = ($urandom % 4) != 0;
                rd_data  = pat(cur_addr, rd_k);
            end else begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
            #2;
            if (!rst) begin
                if (cmd_valid && cmd_ready) begin
                    if (region_clk_en) bad_en_hs++;
                    if (ncmd < 256) cmd_log[ncmd] = cmd_data;
                    ncmd++;
                    if (want_addr) begin
                        cur_addr = cmd_data; rd_left = 41; rd_k = 0; want_addr = 1'b0;
                    end else if (cmd_data == W_RD) begin
                        want_addr = 1'b1;
                    end
                end
                if (rd_valid && rd_ready) begin
                    if (region_clk_en) bad_en_hs++;
                    rd_k++; rd_left--;
                end
                if (rec_valid && rec_ready) begin
                    if (nrec < 256) begin
                        rec_log[nrec]  = rec_data;
                        last_log[nrec] = rec_last;
                    end
                    if (rec_last) busy_at_last = busy;
                    nrec++;
                end
            end
        end
    end

    task automatic run_save(input int n, input logic [31:0] a [MAXF], input bit poke);
        int exp_len, bad, first_i, lasts;
        logic [31:0] exp_w, act_w;
        clear_logs();
        @(negedge clk);
        frame_cnt = CNT_W'(n);
        for (int i = 0; i < MAXF; i++) frame_addrs[i*32 +: 32] = a[i];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(region_clk_en == 1'b0, "R3", "clock enable after start", 32'(region_clk_en), 0);
        check(busy == 1'b1, "R2", "busy after valid start", 32'(busy), 1);
        if (poke) begin
            repeat (5) @(negedge clk);
            frame_cnt   = CNT_W'((n % MAXF) + 1);
            frame_addrs = ~frame_addrs;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int c = 0; c < 20000 && busy; c++) @(negedge clk);
        check(busy == 1'b0, "R8", "busy cleared at end", 32'(busy), 0);
        check(region_clk_en == 1'b1, "R8", "clock enable restored with busy low", 32'(region_clk_en), 1);
        check(bad_en_hs == 0, "R3", "handshakes with clock running", 32'(bad_en_hs), 0);
        check(busy_at_last == 1'b1, "R8", "busy at last record word", 32'(busy_at_last), 1);
        // command sequence (R4)
        check(ncmd == 3 + 2 * n, "R4", "command count", 32'(ncmd), 32'(3 + 2 * n));
        bad = 0; first_i = -1; act_w = '0; exp_w = '0;
        for (int i = 0; i < ncmd && i < 256; i++) begin
            logic [31:0] e;
            if (i == 0) e = W_OPT;
            else if (i == 1) e = W_CAP;
            else if (i == 2 + 2 * n) e = W_RCAP;
            else if (((i - 2) % 2) == 0) e = W_RD;
            else e = a[(i - 3) / 2];
            if (cmd_log[i] !== e) begin
                bad++;
                if (first_i < 0) begin first_i = i; act_w = cmd_log[i]; exp_w = e; end
            end
        end
        check(bad == 0, "R4", "command order", act_w, exp_w);
        // record content (R5, R6)
        exp_len = 1 + n + 41 * n;
        check(nrec == exp_len, "R5", "record length", 32'(nrec), 32'(exp_len));
        bad = 0; first_i = -1; lasts = 0;
        for (int i = 0; i < nrec && i < 256; i++) begin
            logic [31:0] e;
            if (i == 0) e = 32'(n);
            else if (i <= n) e = a[i - 1];
            else e = pat(a[(i - 1 - n) / 41], (i - 1 - n) % 41);
            if (rec_log[i] !== e) begin
                bad++;
                if (first_i < 0) begin first_i = i; act_w = rec_log[i]; exp_w = e; end
            end
            if (last_log[i]) lasts++;
        end
        check(bad == 0, "R6", "record words", act_w, exp_w);
        check(lasts == 1 && nrec > 0 && nrec <= 256 && last_log[nrec - 1] == 1'b1,
              "R7", "last flag count and place", 32'(lasts), 1);
        if (poke) begin
            repeat (6) @(negedge clk);
            check(busy == 1'b0 && ncmd == 3 + 2 * n, "R9", "no save after poke",
                  32'(busy), 0);
        end
    endtask

    task automatic try_bad(input int n);
        clear_logs();
        @(negedge clk);
        frame_cnt = CNT_W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        check(busy == 1'b0 && region_clk_en == 1'b1, "R2", "out-of-range count ignored",
              32'({busy, region_clk_en}), 32'h1);
        check(ncmd == 0 && nrec == 0, "R2", "no traffic for out-of-range count",
              32'(ncmd + nrec), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] a [MAXF];
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(busy == 1'b0, "R1", "busy after reset", 32'(busy), 0);
        check(region_clk_en == 1'b1, "R1", "clock enable after reset", 32'(region_clk_en), 1);
        check(cmd_valid == 1'b0 && rec_valid == 1'b0, "R1", "no valid after reset",
              32'({cmd_valid, rec_valid}), 0);
        // directed: single frame, full list
        for (int i = 0; i < MAXF; i++) a[i] = 32'h0040_0000 + 32'(i) * 32'h100;
        run_save(1, a, 1'b0);
        run_save(MAXF, a, 1'b0);
        // out-of-range counts
        try_bad(0);
        try_bad(MAXF + 1);
        // start while busy (R9)
        for (int i = 0; i < MAXF; i++) a[i] = 32'hC0DE_0000 ^ 32'(i * 7);
        run_save(3, a, 1'b1);
        // random saves
        for (int r = 0; r < 8; r++) begin
            for (int i = 0; i < MAXF; i++) a[i] = $urandom;
            run_save(int'($urandom % MAXF) + 1, a, 1'b0);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule